// File: doc/BRIEF.md
# Cell Interrupt Status Aggregator

This block gathers single-cycle or level status signals from the receive and transmit halves of a cell-based datapath. It turns each signal into an interrupt event. A 0-to-1 transition on a status input sets a sticky indication bit. The bit stays set until software reads the register that holds it. Software never needs to poll the raw status lines, and a status that stays high produces exactly one event.

Two per-bit enable registers, one for receive and one for transmit, mask the indication bits. The surviving bits pass through three enables stacked on top of each other: a summary enable per source group, a single port enable and a global pin enable. Together they drive one registered, active-low interrupt output.

A small synchronous register bus gives access to every enable and indication register. It has a write strobe, a read strobe, an address and byte-wide data. Read data appears on the cycle after the read strobe.

Top module: `cell_irq_agg`

## Requirements
- R1: An indication bit is set only on a clock edge where its status input is 1 and was 0 on the previous edge. A status input held high does not set the bit again after a read has cleared it.
- R2: A read strobe at address 1 (receive indication) or address 3 (transmit indication) clears every latched bit of that register. `rdata_o` presents the value from before the clear on the cycle after the strobe.
- R3: If a status input rises on the same edge that its indication register is read, the read returns the old value and the new bit stays set afterwards.
- R4: Address 0 is the receive enable register. It has bits 0 to 2 for `rx_stat_i[2:0]` and bits 4 to 7 for `rx_stat_i[6:3]`. Bit 3 is reserved and always reads 0. The receive indication register at address 1 uses the same bit layout.
- R5: The transmit indication register at address 3 holds `tx_stat_i[4:0]` in bits 4:0, and its upper bits read 0. The transmit enable register at address 2 uses the same layout.
- R6: A receive bit reaches the pin only when all of the following are set: its enable bit, summary bit 0 (address 4), port bit 0 (address 5) and pin-enable bit 3 of the mode register (address 6). A transmit bit follows the same rule but uses summary bit 1. Reads of address 4 return only bits 1:0, address 5 only bit 0, address 6 only bit 3, and address 7 returns 0.
- R7: `irq_n_o` is active low and registered. It goes low on the clock edge after an enabled indication bit becomes set.
- R8: `irq_n_o` returns high on the clock edge after the edge that clears the last enabled indication bit, or after the edge that clears an enable in its path.
- R9: After reset, every enable and indication register reads 0 and `irq_n_o` is high.
- R10: Writes to the indication addresses (1 and 3) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| rx_stat_i | input | 7 | Receive event status inputs |
| tx_stat_i | input | 5 | Transmit event status inputs |
| irq_n_o | output | 1 | Active-low interrupt output |

## Verification
The bench builds the block with the package defaults: a byte-wide register, seven receive sources with the reserved hole at bit 3, and five transmit sources. With this configuration every bit of both enable registers and every level of the enable chain can be switched one at a time. This lets each level be shown to block the pin on its own. The narrow source widths also let the bench cover the reserved hole, the zero-extended transmit readback and same-edge collisions between a read and a rising status.

// File: rtl/cell_irq_pkg.sv
package cell_irq_pkg;
    localparam int REG_W       = 8;
    localparam int ADDR_W      = 3;
    localparam int RX_HOLE     = 3;
    localparam int RX_N        = REG_W - 1;
    localparam int TX_N        = 5;
    localparam int PIN_POS     = 3;
    localparam int GRP_N       = 2;
    localparam int GRP_RX      = 0;
    localparam int GRP_TX      = 1;

    localparam logic [ADDR_W-1:0] ADR_RX_EN  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_RX_IND = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_TX_EN  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_TX_IND = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_GRP    = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_PORT   = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_MODE   = 3'd6;
endpackage

// File: rtl/cell_irq_edge.sv
module cell_irq_edge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat_i,
    input  logic         clr_i,
    output logic [N-1:0] ind_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] ind;
    } st_t;

    st_t          st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        st_d      = st_q;
        rise      = stat_i & ~st_q.prev;
        st_d.prev = stat_i;
        // a rise on the clearing edge survives the clear
        st_d.ind  = (clr_i ? '0 : st_q.ind) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ind_o = st_q.ind;
endmodule

// File: rtl/cell_irq_gate.sv
module cell_irq_gate #(
    parameter int RX_N = 7,
    parameter int TX_N = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RX_N-1:0] rx_ind_i,
    input  logic [RX_N-1:0] rx_en_i,
    input  logic [TX_N-1:0] tx_ind_i,
    input  logic [TX_N-1:0] tx_en_i,
    input  logic [1:0]      grp_en_i,
    input  logic            port_en_i,
    input  logic            pin_en_i,
    output logic            irq_n_o
);
    typedef struct packed {
        logic irq_n;
    } st_t;

    st_t        st_d, st_q;
    logic [1:0] grp_hit;

    always_comb begin
        grp_hit[0] = |(rx_ind_i & rx_en_i);
        grp_hit[1] = |(tx_ind_i & tx_en_i);
        st_d       = st_q;
        st_d.irq_n = ~((|(grp_hit & grp_en_i)) & port_en_i & pin_en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{irq_n: 1'b1};
        else        st_q <= st_d;
    end

    assign irq_n_o = st_q.irq_n;
endmodule

// File: rtl/cell_irq_agg.sv
module cell_irq_agg
    import cell_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic [RX_N-1:0]   rx_stat_i,
    input  logic [TX_N-1:0]   tx_stat_i,
    output logic              irq_n_o
);
    typedef struct packed {
        logic [RX_N-1:0]  rx_en;
        logic [TX_N-1:0]  tx_en;
        logic [GRP_N-1:0] grp;
        logic             port;
        logic             pin;
        logic [REG_W-1:0] rdata;
    } regs_t;

    regs_t            r_d, r_q;
    logic [RX_N-1:0]  rx_ind;
    logic [TX_N-1:0]  tx_ind;
    logic [RX_N-1:0]  rx_en_wr;
    logic [REG_W-1:0] rx_en_view;
    logic [REG_W-1:0] rx_ind_view;
    logic [REG_W-1:0] rd_mux;
    logic             clr_rx, clr_tx;
    logic             port_en, pin_en;

    // compact receive vector <-> register view with the reserved hole
    for (genvar g = 0; g < REG_W; g++) begin : g_view
        if (g < RX_HOLE) begin : g_lo
            assign rx_en_view[g]  = r_q.rx_en[g];
            assign rx_ind_view[g] = rx_ind[g];
            assign rx_en_wr[g]    = wdata_i[g];
        end else if (g == RX_HOLE) begin : g_hole
            assign rx_en_view[g]  = 1'b0;
            assign rx_ind_view[g] = 1'b0;
        end else begin : g_hi
            assign rx_en_view[g]  = r_q.rx_en[g-1];
            assign rx_ind_view[g] = rx_ind[g-1];
            assign rx_en_wr[g-1]  = wdata_i[g];
        end
    end

    always_comb begin
        clr_rx = rd_en_i && (addr_i == ADR_RX_IND);
        clr_tx = rd_en_i && (addr_i == ADR_TX_IND);
        case (addr_i)
            ADR_RX_EN:  rd_mux = rx_en_view;
            ADR_RX_IND: rd_mux = rx_ind_view;
            ADR_TX_EN:  rd_mux = REG_W'(r_q.tx_en);
            ADR_TX_IND: rd_mux = REG_W'(tx_ind);
            ADR_GRP:    rd_mux = REG_W'(r_q.grp);
            ADR_PORT:   rd_mux = REG_W'(r_q.port);
            ADR_MODE:   rd_mux = REG_W'(r_q.pin) << PIN_POS;
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            case (addr_i)
                ADR_RX_EN: r_d.rx_en = rx_en_wr;
                ADR_TX_EN: r_d.tx_en = wdata_i[TX_N-1:0];
                ADR_GRP:   r_d.grp   = wdata_i[GRP_N-1:0];
                ADR_PORT:  r_d.port  = wdata_i[0];
                ADR_MODE:  r_d.pin   = wdata_i[PIN_POS];
                default:   ;
            endcase
        end
        if (rd_en_i) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign port_en = r_q.port;
    assign pin_en  = r_q.pin;
    assign rdata_o = r_q.rdata;

    cell_irq_edge #(.N(RX_N)) u_rx_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (rx_stat_i),
        .clr_i  (clr_rx),
        .ind_o  (rx_ind)
    );

    cell_irq_edge #(.N(TX_N)) u_tx_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (tx_stat_i),
        .clr_i  (clr_tx),
        .ind_o  (tx_ind)
    );

    cell_irq_gate #(.RX_N(RX_N), .TX_N(TX_N)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_ind_i  (rx_ind),
        .rx_en_i   (r_q.rx_en),
        .tx_ind_i  (tx_ind),
        .tx_en_i   (r_q.tx_en),
        .grp_en_i  (r_q.grp),
        .port_en_i (port_en),
        .pin_en_i  (pin_en),
        .irq_n_o   (irq_n_o)
    );
endmodule

// File: rtl/cell_irq_chk.sv
module cell_irq_chk
    import cell_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [REG_W-1:0]  rdata_o,
    input logic [RX_N-1:0]   rx_stat_i,
    input logic [TX_N-1:0]   tx_stat_i,
    input logic [RX_N-1:0]   rx_ind,
    input logic [TX_N-1:0]   tx_ind,
    input logic              port_en,
    input logic              pin_en,
    input logic              irq_n_o
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         age <= '0;
        else if (age != 3)  age <= age + 2'd1;
    end

    // R1
    rx_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3) |-> ((rx_ind & ~$past(rx_ind) & ~($past(rx_stat_i) & ~$past(rx_stat_i, 2))) == '0));

    // R1
    tx_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3) |-> ((tx_ind & ~$past(tx_ind) & ~($past(tx_stat_i) & ~$past(tx_stat_i, 2))) == '0));

    // R2
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADR_RX_IND) |=> ((rx_ind & ~$past(rx_stat_i)) == '0));

    // R2
    tx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADR_TX_IND) |=> ((tx_ind & ~$past(tx_stat_i)) == '0));

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == ADR_RX_EN || addr_i == ADR_RX_IND)) |=> (rdata_o[RX_HOLE] == 1'b0));

    // R6
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 0 && !irq_n_o) |-> ($past(pin_en) && $past(port_en)));

    // R9
    reset_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 0) |-> irq_n_o);
endmodule

bind cell_irq_agg cell_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .rdata_o   (rdata_o),
    .rx_stat_i (rx_stat_i),
    .tx_stat_i (tx_stat_i),
    .rx_ind    (rx_ind),
    .tx_ind    (tx_ind),
    .port_en   (port_en),
    .pin_en    (pin_en),
    .irq_n_o   (irq_n_o)
);

// File: tb/test_cell_irq_agg.sv
`timescale 1ns/1ps
module test_cell_irq_agg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic [6:0] rx_stat_i = '0;
    logic [4:0] tx_stat_i = '0;
    logic       irq_n_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cell_irq_agg i_cell_irq_agg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .rx_stat_i (rx_stat_i),
        .tx_stat_i (tx_stat_i),
        .irq_n_o   (irq_n_o)
    );

    typedef struct packed {
        logic [7:0] rx_en;
        logic [7:0] tx_en;
        logic [7:0] grp;
        logic [7:0] port;
        logic [7:0] mode;
        logic [6:0] rx_ev;
        logic [4:0] tx_ev;
        logic       exp_irq_n;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{8'hFF, 8'h1F, 8'h03, 8'h01, 8'h08, 7'h01, 5'h00, 1'b0},
        '{8'h02, 8'h1F, 8'h03, 8'h01, 8'h08, 7'h01, 5'h00, 1'b1},
        '{8'hFF, 8'h1F, 8'h02, 8'h01, 8'h08, 7'h08, 5'h00, 1'b1},
        '{8'hFF, 8'h1F, 8'h03, 8'h00, 8'h08, 7'h40, 5'h00, 1'b1},
        '{8'hFF, 8'h1F, 8'h03, 8'h01, 8'h00, 7'h04, 5'h00, 1'b1},
        '{8'h00, 8'h04, 8'h02, 8'h01, 8'h08, 7'h00, 5'h04, 1'b0},
        '{8'h00, 8'h1F, 8'h01, 8'h01, 8'h08, 7'h00, 5'h10, 1'b1},
        '{8'h80, 8'h00, 8'h01, 8'h01, 8'h08, 7'h40, 5'h03, 1'b0}
    };

    function automatic logic [7:0] rxmap(input logic [6:0] c);
        return {c[6:3], 1'b0, c[2:0]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic pulse(input logic [6:0] rx, input logic [4:0] tx);
        @(negedge clk);
        rx_stat_i = rx; tx_stat_i = tx;
        @(negedge clk);
        rx_stat_i = '0; tx_stat_i = '0;
    endtask

    task automatic all_on;
        wr(3'd0, 8'hFF); wr(3'd2, 8'h1F); wr(3'd4, 8'h03);
        wr(3'd5, 8'h01); wr(3'd6, 8'h08);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        check("R9 irq_n after reset", {7'b0, irq_n_o}, 8'h01);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R9 register after reset", v, 8'h00);
        end

        // table: R6 gating, R7 assertion, R4/R5 layouts, R8 release
        for (int i = 0; i < NV; i++) begin
            rd(3'd1, v); rd(3'd3, v);
            wr(3'd0, TBL[i].rx_en); wr(3'd2, TBL[i].tx_en);
            wr(3'd4, TBL[i].grp);   wr(3'd5, TBL[i].port);
            wr(3'd6, TBL[i].mode);
            pulse(TBL[i].rx_ev, TBL[i].tx_ev);
            @(negedge clk);
            check("R6 R7 irq_n per gating vector", {7'b0, irq_n_o}, {7'b0, TBL[i].exp_irq_n});
            rd(3'd1, v);
            check("R4 receive indication layout", v, rxmap(TBL[i].rx_ev));
            rd(3'd3, v);
            check("R5 transmit indication layout", v, {3'b0, TBL[i].tx_ev});
            @(negedge clk);
            check("R8 irq_n released after reads", {7'b0, irq_n_o}, 8'h01);
        end

        // R4 / R6: readback widths and reserved hole
        wr(3'd0, 8'hFF); rd(3'd0, v); check("R4 reserved bit reads 0", v, 8'hF7);
        wr(3'd2, 8'hFF); rd(3'd2, v); check("R5 tx enable width", v, 8'h1F);
        wr(3'd4, 8'hFF); rd(3'd4, v); check("R6 summary width", v, 8'h03);
        wr(3'd5, 8'hFF); rd(3'd5, v); check("R6 port width", v, 8'h01);
        wr(3'd6, 8'hFF); rd(3'd6, v); check("R6 mode pin bit only", v, 8'h08);
        rd(3'd7, v); check("R6 unused address", v, 8'h00);

        // R1: held status fires once
        all_on();
        @(negedge clk); rx_stat_i = 7'h01;
        repeat (3) @(negedge clk);
        rd(3'd1, v); check("R1 first read of held status", v, 8'h01);
        rd(3'd1, v); check("R1 no re-set while held high", v, 8'h00);
        @(negedge clk);
        check("R1 irq_n stays high while held", {7'b0, irq_n_o}, 8'h01);
        rx_stat_i = '0;

        // R3: rise on the reading edge
        @(negedge clk);
        rx_stat_i = 7'h02; rd_en_i = 1'b1; addr_i = 3'd1;
        @(negedge clk);
        rd_en_i = 1'b0; rx_stat_i = '0;
        check("R3 read returns old value", rdata_o, 8'h00);
        rd(3'd1, v); check("R3 colliding event kept", v, 8'h02);

        // R10: writes to indication addresses ignored
        pulse(7'h01, 5'h00);
        wr(3'd1, 8'h00);
        rd(3'd1, v); check("R10 write to rx indication ignored", v, 8'h01);
        wr(3'd3, 8'hFF);
        rd(3'd3, v); check("R10 write to tx indication ignored", v, 8'h00);

        // R8: exact release timing after the clearing read
        pulse(7'h00, 5'h01);
        @(negedge clk);
        check("R7 irq_n low on tx event", {7'b0, irq_n_o}, 8'h00);
        rd(3'd3, v);
        check("R8 irq_n still low right after read edge", {7'b0, irq_n_o}, 8'h00);
        @(negedge clk);
        check("R8 irq_n high one edge later", {7'b0, irq_n_o}, 8'h01);

        // R8: release by clearing pin enable
        pulse(7'h00, 5'h08);
        @(negedge clk);
        check("R7 irq_n low before enable clear", {7'b0, irq_n_o}, 8'h00);
        wr(3'd6, 8'h00);
        check("R8 irq_n low right after enable write", {7'b0, irq_n_o}, 8'h00);
        @(negedge clk);
        check("R8 irq_n high after enable clear", {7'b0, irq_n_o}, 8'h01);
        rd(3'd3, v); check("R2 tx indication still latched", v, 8'h08);
        rd(3'd3, v); check("R2 tx indication cleared by read", v, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule